// File: doc/BRIEF.md
# Hierarchical interrupt status register bank

This register bank records interrupt events for a device with twelve transmit queues and a set of global sources. The per-queue detail is too wide for one word, so it lives in four secondary status registers, each with one bit per queue. A primary status register holds the global source bits together with four summary bits. Each summary bit is set while any bit of its secondary register is set. A single registered interrupt line is raised when any primary bit that the enable mask lets through is set.

Software has two ways to acknowledge events. The first is a read of a read-and-clear alias of the primary register. In one clock this read returns the primary value, copies all four secondaries into shadow registers and clears every status bit. The second is a write-one-to-clear to the primary or to a secondary register, which clears only the positions written as one. Neither path ever drops an event that arrives in the cycle of the clear. The register port is a simple synchronous port. Read data appears in the cycle after the request.

Top module: `irq_status_bank`

## Requirements
- R1: After reset all status, shadow and mask bits are zero, `irq` is 0 and `rdata` is 0.
- R2: A one on a `glb_evt` or `q_evt` bit sets its status bit at the next clock edge. The bit then stays one until it is cleared. A level held for several cycles leaves the bit set, with no other effect.
- R3: The primary value is {global bits, summary bits}. Bits [3:0] are the summaries of secondaries 0..3, and bits [15:4] are `glb_evt[11:0]`. Secondary n holds `q_evt[12n+11:12n]`. A summary bit is the OR of its secondary, so it drops once that secondary is cleared.
- R4: A write to address 0 (primary) or to addresses 1..4 (secondaries 0..3) clears only the status bits whose `wdata` bit is one. For the primary, `wdata[15:4]` maps to the global bits. For a secondary, `wdata[11:0]` maps to its queue bits.
- R5: Writing ones to primary bits [3:0] has no effect on the summaries or on the secondary registers.
- R6: When an event and a clear for the same bit fall in the same cycle, the bit is one afterwards.
- R7: A read of address 5 returns the primary value as it stood before that edge. At the same edge it copies secondary n into shadow n and clears all primary and secondary bits.
- R8: An event that arrives in the same cycle as a read of address 5 is set after that read. It is not included in the shadows.
- R9: Shadow n is read at address 6+n. Reading a shadow changes no status bit, and a shadow keeps its value until the next read of address 5.
- R10: `irq` is the OR of (primary AND mask), registered, so it follows the state with a one-clock delay. The mask is written with `wdata[15:0]` at address 10 and read back there.
- R11: Read data is the addressed register, zero-extended, and appears one clock after the request. Unmapped addresses read 0. Writes to addresses 5..9 and to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_evt | input | 12 | Global event inputs |
| q_evt | input | 48 | Queue event inputs, twelve per secondary group |
| cs | input | 1 | Register access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | 1 | Registered interrupt request |

## Verification
A lost or wrongly cleared status bit shows at the ports in two ways. It shows on the next read of the primary, a secondary or a shadow, and it shows one clock later on `irq` if the mask enables that bit. A snapshot that is not atomic shows as a shadow that differs from the secondary value just before the alias read, or as an event from the alias cycle that is missing on the next read. A summary that drifts away from its secondary shows as a mismatch in primary bits [3:0] on the very next read.

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NQ = 12,
  parameter int NG = 12,
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NG-1:0]    glb_evt,
  input  logic [4*NQ-1:0]  q_evt,
  input  logic             cs,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             irq
);
  localparam int NS = 4;
  localparam int PW = NS + NG;
  localparam logic [AW-1:0] A_PRI  = AW'(0);
  localparam logic [AW-1:0] A_SEC0 = AW'(1);
  localparam logic [AW-1:0] A_RAC  = AW'(5);
  localparam logic [AW-1:0] A_SHD0 = AW'(6);
  localparam logic [AW-1:0] A_MASK = AW'(10);

  logic [NS-1:0][NQ-1:0] sec_q, shd_q, sec_clr;
  logic [NG-1:0]         glb_q, glb_clr;
  logic [PW-1:0]         mask_q, prim;
  logic [NS-1:0]         summ;
  logic [DW-1:0]         rmux;
  logic                  unused_hi;

  wire rd  = cs & ~we;
  wire wr  = cs & we;
  wire rac = rd && (addr == A_RAC);

  assign unused_hi = ^wdata[DW-1:PW];
  assign prim      = {glb_q, summ};
  assign glb_clr   = rac ? '1 : (wr && addr == A_PRI) ? wdata[PW-1:NS] : '0;

  for (genvar i = 0; i < NS; i++) begin : g_sec
    assign summ[i]    = |sec_q[i];
    assign sec_clr[i] = rac ? '1 :
                        (wr && addr == A_SEC0 + AW'(i)) ? wdata[NQ-1:0] : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sec_q[i] <= '0;
        shd_q[i] <= '0;
      end else begin
        sec_q[i] <= (sec_q[i] & ~sec_clr[i]) | q_evt[i*NQ +: NQ];
        if (rac) shd_q[i] <= sec_q[i];
      end
    end
  end

  always_comb begin
    rmux = '0;
    case (addr)
      A_PRI, A_RAC: rmux = DW'(prim);
      A_MASK:       rmux = DW'(mask_q);
      default:
        for (int i = 0; i < NS; i++) begin
          if (addr == A_SEC0 + AW'(i)) rmux = DW'(sec_q[i]);
          if (addr == A_SHD0 + AW'(i)) rmux = DW'(shd_q[i]);
        end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glb_q  <= '0;
      mask_q <= '0;
      rdata  <= '0;
      irq    <= 1'b0;
    end else begin
      glb_q <= (glb_q & ~glb_clr) | glb_evt;
      if (wr && addr == A_MASK) mask_q <= wdata[PW-1:0];
      if (rd) rdata <= rmux;
      irq <= |(prim & mask_q);
    end
  end
endmodule

// File: rtl/irq_status_bank_chk.sv
module irq_status_bank_chk #(
  parameter int NQ = 12,
  parameter int NG = 12,
  parameter int AW = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs,
  input logic                  we,
  input logic [AW-1:0]         addr,
  input logic [NG-1:0]         glb_evt,
  input logic [4*NQ-1:0]       q_evt,
  input logic                  irq,
  input logic [4+NG-1:0]       prim,
  input logic [4+NG-1:0]       mask_q,
  input logic [3:0][NQ-1:0]    shd_q
);
  localparam int NS = 4;
  localparam int PW = NS + NG;
  wire rac    = cs && !we && addr == AW'(5);
  wire pri_wr = cs && we && addr == AW'(0);

  AST_MASK_OFF_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !irq); // R10

  AST_GLB_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_evt != '0) |=> ((prim[PW-1:NS] & $past(glb_evt)) == $past(glb_evt))); // R6

  AST_RAC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rac && glb_evt == '0 && q_evt == '0) |=> (prim == '0)); // R7

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rac |=> $stable(shd_q)); // R9

  AST_SUMMARY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_wr && q_evt == '0) |=> (prim[NS-1:0] == $past(prim[NS-1:0]))); // R5

  for (genvar i = 0; i < NS; i++) begin : g_sum
    AST_QUEUE_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
      (|q_evt[i*NQ +: NQ]) |=> prim[i]); // R3
  end
endmodule

bind irq_status_bank irq_status_bank_chk #(.NQ(NQ), .NG(NG), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
  .glb_evt(glb_evt), .q_evt(q_evt), .irq(irq), .prim(prim),
  .mask_q(mask_q), .shd_q(shd_q)
);

// File: tb/irq_status_bank_bench.sv
module irq_status_bank_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] glb_evt = '0;
  logic [47:0] q_evt = '0;
  logic        cs = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  irq_status_bank u_irq_status_bank (
    .clk(clk), .rst_n(rst_n), .glb_evt(glb_evt), .q_evt(q_evt),
    .cs(cs), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference
  logic [11:0] m_glb, m_sec[4], m_shd[4];
  logic [15:0] m_mask, m_p;
  logic [31:0] m_rd;
  logic        m_irq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_glb = 0; m_mask = 0; m_rd = 0; m_irq = 0;
      for (int i = 0; i < 4; i++) begin m_sec[i] = 0; m_shd[i] = 0; end
    end else begin
      m_p = {m_glb, |m_sec[3], |m_sec[2], |m_sec[1], |m_sec[0]};
      m_irq = |(m_p & m_mask);
      if (cs && !we) begin
        if (addr == 0 || addr == 5) m_rd = {16'h0, m_p};
        else if (addr >= 1 && addr <= 4) m_rd = {20'h0, m_sec[addr-1]};
        else if (addr >= 6 && addr <= 9) m_rd = {20'h0, m_shd[addr-6]};
        else if (addr == 10) m_rd = {16'h0, m_mask};
        else m_rd = 0;
      end
      if (cs && !we && addr == 5) begin
        for (int i = 0; i < 4; i++) begin m_shd[i] = m_sec[i]; m_sec[i] = 0; end
        m_glb = 0;
      end else if (cs && we) begin
        if (addr == 0) m_glb = m_glb & ~wdata[15:4];
        else if (addr >= 1 && addr <= 4) m_sec[addr-1] = m_sec[addr-1] & ~wdata[11:0];
        else if (addr == 10) m_mask = wdata[15:0];
      end
      m_glb = m_glb | glb_evt;
      for (int i = 0; i < 4; i++) m_sec[i] = m_sec[i] | q_evt[i*12 +: 12];
    end
  end

  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n) begin
      n_cmp += 2;
      if (rdata !== m_rd) begin
        n_bad++;
        $display("FAIL %s rdata actual %h expected %h", cur_req, rdata, m_rd);
      end
      if (irq !== m_irq) begin
        n_bad++;
        $display("FAIL %s irq actual %b expected %b", cur_req, irq, m_irq);
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(logic c, logic w, logic [3:0] a, logic [31:0] d,
                    logic [11:0] ge, logic [47:0] qe);
    @(negedge clk);
    cs = c; we = w; addr = a; wdata = d; glb_evt = ge; q_evt = qe;
    @(posedge clk); #1;
    cs = 0; we = 0; glb_evt = 0; q_evt = 0;
  endtask

  task automatic rd(logic [3:0] a); op(1, 0, a, 0, 0, 0); endtask
  task automatic wr(logic [3:0] a, logic [31:0] d); op(1, 1, a, d, 0, 0); endtask
  task automatic idle(); op(0, 0, 0, 0, 0, 0); endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P*150000);
    n_bad++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1", rdata, 0); chk("R1", {31'h0, irq}, 0);
    rd(10); chk("R1", rdata, 0);
    rd(6);  chk("R1", rdata, 0);
    rd(0);  chk("R1", rdata, 0);

    cur_req = "R2";
    op(0, 0, 0, 0, 12'h001, 48'h1 << 15);
    rd(0); chk("R3", rdata, 32'h12);
    rd(2); chk("R2", rdata, 32'h8);
    for (int k = 0; k < 3; k++) op(0, 0, 0, 0, 12'h004, 0);
    rd(0); chk("R2", rdata, 32'h52);

    cur_req = "R4";
    wr(0, 32'h40); rd(0); chk("R4", rdata, 32'h12);

    cur_req = "R5";
    wr(0, 32'hF); rd(0); chk("R5", rdata, 32'h12);
    rd(2); chk("R5", rdata, 32'h8);

    cur_req = "R3";
    wr(2, 32'h8); rd(0); chk("R3", rdata, 32'h10);

    cur_req = "R6";
    op(1, 1, 1, 32'hFFF, 0, 48'h1);
    rd(1); chk("R6", rdata, 32'h1);
    op(1, 1, 0, 32'h10, 12'h001, 0);
    rd(0); chk("R6", rdata, 32'h11);

    cur_req = "R10";
    wr(10, 32'h1); chk("R10", {31'h0, irq}, 0);
    idle(); chk("R10", {31'h0, irq}, 1);
    rd(10); chk("R10", rdata, 32'h1);

    cur_req = "R7";
    op(0, 0, 0, 0, 0, (48'h5 << 24) | (48'h800 << 36));
    op(1, 0, 5, 0, 0, 48'h80);
    chk("R7", rdata, 32'h1D);
    rd(0); chk("R8", rdata, 32'h1);
    rd(1); chk("R8", rdata, 32'h80);
    rd(6); chk("R7", rdata, 32'h1);
    rd(7); chk("R7", rdata, 32'h0);
    rd(8); chk("R7", rdata, 32'h5);
    rd(9); chk("R7", rdata, 32'h800);
    rd(3); chk("R7", rdata, 32'h0);

    cur_req = "R9";
    rd(1); chk("R9", rdata, 32'h80);
    rd(9); chk("R9", rdata, 32'h800);

    cur_req = "R11";
    rd(15); chk("R11", rdata, 0);
    wr(6, 32'hFFF); wr(5, 32'hFFFF); wr(13, 32'hFFFF);
    rd(6); chk("R11", rdata, 32'h1);
    rd(0); chk("R11", rdata, 32'h1);

    cur_req = "R2 R4 R6 R7 R8 R10 random";
    for (int k = 0; k < 2000; k++) begin
      logic [47:0] qe;
      logic [11:0] ge;
      qe = '0; ge = '0;
      if ($urandom_range(0, 3) == 0) qe = 48'h1 << $urandom_range(0, 47);
      if ($urandom_range(0, 3) == 0) ge = 12'h1 << $urandom_range(0, 11);
      op($urandom_range(0, 1), $urandom_range(0, 1), 4'($urandom_range(0, 15)),
         $urandom, ge, qe);
    end
    idle(); idle();
    finish_run();
  end
endmodule